// File: doc/BRIEF.md
# Half-Precision Unordered Compare Unit

This block takes two IEEE binary16 operands and turns their relation into a condition-flag pattern for a processor flags register. It sorts each operand into one of six classes: zero, subnormal, normal, infinity, quiet NaN or signalling NaN. It then orders the pair as greater, less, equal or unordered. Finally it encodes that order on the zero, parity and carry flags, and it drives the overflow, sign and auxiliary-carry flags to zero.

Two exception conditions are tracked. Invalid is raised only when a signalling NaN is present. Denormal is raised when a subnormal operand is consumed. Both are recorded in sticky status bits whether they are masked or not. When a raised exception is unmasked, the flag write is suppressed and the held flags keep their previous value. Results appear one clock after the request strobe, together with a single-cycle valid pulse.

Top module: `hcmp_unit`

## Requirements
- R1: When either operand is a NaN (exponent bits [14:10] all ones, fraction [9:0] nonzero), the flags are written as zf=1, pf=1, cf=1.
- R2: When operand A is greater than operand B, the flags are written as zf=0, pf=0, cf=0.
- R3: When operand A is less than operand B, the flags are written as zf=0, pf=0, cf=1. Ordering is by sign and magnitude: for negative values, a larger magnitude is the smaller value. Subnormals and infinities take part in this ordering.
- R4: When the operands are equal, the flags are written as zf=1, pf=0, cf=0. Positive zero (0x0000) and negative zero (0x8000) count as equal.
- R5: of_o, sf_o and af_o read 0 at all times after reset, and every flag write drives them to 0.
- R6: Invalid is raised only when an operand is a signalling NaN, which is a NaN with fraction bit 9 clear. A quiet NaN (fraction bit 9 set) gives the unordered result and raises no invalid.
- R7: Denormal is raised when either operand is subnormal: exponent zero and fraction nonzero.
- R8: A mask input at 1 masks its exception. When a raised exception is unmasked, flag_we_o stays 0 and zf_o/pf_o/cf_o keep their previous values.
- R9: stat_inv_o and stat_den_o are sticky. Each is set by its exception even when that exception is masked, and only reset clears it.
- R10: For each cycle with valid_i high, valid_o is high exactly one cycle later. flag_we_o is high only together with valid_o, when the write is allowed.
- R11: In reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Compare request strobe |
| op_a_i | input | 16 | Operand A, binary16 |
| op_b_i | input | 16 | Operand B, binary16 |
| mask_inv_i | input | 1 | 1 masks the invalid exception |
| mask_den_i | input | 1 | 1 masks the denormal exception |
| valid_o | output | 1 | Result pulse, one cycle after valid_i |
| zf_o | output | 1 | Held zero flag |
| pf_o | output | 1 | Held parity flag |
| cf_o | output | 1 | Held carry flag |
| of_o | output | 1 | Overflow flag, always 0 |
| sf_o | output | 1 | Sign flag, always 0 |
| af_o | output | 1 | Auxiliary-carry flag, always 0 |
| flag_we_o | output | 1 | Flag write enable for this result |
| stat_inv_o | output | 1 | Sticky invalid status |
| stat_den_o | output | 1 | Sticky denormal status |

## Verification
The bench compares positive zero against negative zero. A design that compared raw bit patterns would report less-than there instead of equal. It pairs negative values of different magnitude, where an unsigned magnitude compare would invert the result. It also uses quiet and signalling NaNs under every mask setting, to catch invalid raised on a quiet NaN, or flags that change despite an unmasked exception. Masked subnormal and infinity operands check that these classes order correctly. They also check that sticky status keeps rising while the flags are still written.

// File: rtl/hcmp_pkg.sv
package hcmp_pkg;
  parameter int EXP_W = 5;
  parameter int MAN_W = 10;
  localparam int OP_W = 1 + EXP_W + MAN_W;

  typedef struct packed {
    logic zero;
    logic sub;
    logic norm;
    logic inf;
    logic qnan;
    logic snan;
  } hcls_t;

  typedef enum logic [1:0] {
    ORD_GT = 2'd0,
    ORD_LT = 2'd1,
    ORD_EQ = 2'd2,
    ORD_UN = 2'd3
  } hord_t;

  typedef struct packed {
    logic zf;
    logic pf;
    logic cf;
  } hflg_t;
endpackage

// File: rtl/hcmp_classify.sv
module hcmp_classify
  import hcmp_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int MW = MAN_W,
  localparam int W = 1 + EW + MW
) (
  input  logic [W-1:0] op_i,
  output hcls_t        cls_o
);
  logic [EW-1:0] exp_f;
  logic [MW-1:0] man_f;
  logic          exp_max, exp_min, man_nz;

  assign exp_f   = op_i[W-2 -: EW];
  assign man_f   = op_i[MW-1:0];
  assign exp_max = &exp_f;
  assign exp_min = ~|exp_f;
  assign man_nz  = |man_f;

  always_comb begin
    cls_o      = '0;
    cls_o.zero = exp_min & ~man_nz;
    cls_o.sub  = exp_min & man_nz;
    cls_o.norm = ~exp_min & ~exp_max;
    cls_o.inf  = exp_max & ~man_nz;
    // quiet bit is the top fraction bit
    cls_o.qnan = exp_max & man_nz & man_f[MW-1];
    cls_o.snan = exp_max & man_nz & ~man_f[MW-1];
  end
endmodule

// File: rtl/hcmp_order.sv
module hcmp_order
  import hcmp_pkg::*;
#(
  parameter int W = OP_W
) (
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  input  hcls_t        cls_a_i,
  input  hcls_t        cls_b_i,
  output hord_t        ord_o
);
  logic         sgn_a, sgn_b;
  logic [W-2:0] mag_a, mag_b;

  assign sgn_a = op_a_i[W-1];
  assign sgn_b = op_b_i[W-1];
  assign mag_a = op_a_i[W-2:0];
  assign mag_b = op_b_i[W-2:0];

  always_comb begin
    if (cls_a_i.qnan | cls_a_i.snan | cls_b_i.qnan | cls_b_i.snan)
      ord_o = ORD_UN;
    else if (cls_a_i.zero & cls_b_i.zero)
      ord_o = ORD_EQ;
    else if (sgn_a != sgn_b)
      ord_o = sgn_a ? ORD_LT : ORD_GT;
    else if (mag_a == mag_b)
      ord_o = ORD_EQ;
    else if (mag_a > mag_b)
      ord_o = sgn_a ? ORD_LT : ORD_GT;
    else
      ord_o = sgn_a ? ORD_GT : ORD_LT;
  end
endmodule

// File: rtl/hcmp_flag_map.sv
module hcmp_flag_map
  import hcmp_pkg::*;
(
  input  hord_t ord_i,
  output hflg_t flg_o
);
  always_comb begin
    unique case (ord_i)
      ORD_GT:  flg_o = '{zf: 1'b0, pf: 1'b0, cf: 1'b0};
      ORD_LT:  flg_o = '{zf: 1'b0, pf: 1'b0, cf: 1'b1};
      ORD_EQ:  flg_o = '{zf: 1'b1, pf: 1'b0, cf: 1'b0};
      default: flg_o = '{zf: 1'b1, pf: 1'b1, cf: 1'b1};
    endcase
  end
endmodule

// File: rtl/hcmp_unit.sv
module hcmp_unit
  import hcmp_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int MW = MAN_W,
  localparam int W = 1 + EW + MW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  input  logic         mask_inv_i,
  input  logic         mask_den_i,
  output logic         valid_o,
  output logic         zf_o,
  output logic         pf_o,
  output logic         cf_o,
  output logic         of_o,
  output logic         sf_o,
  output logic         af_o,
  output logic         flag_we_o,
  output logic         stat_inv_o,
  output logic         stat_den_o
);
  localparam int NOPS = 2;

  logic [W-1:0] ops [NOPS];
  hcls_t        cls [NOPS];
  hord_t        ord;
  hflg_t        flg_n, flg_q;
  logic         exc_inv, exc_den, blk, wr;
  logic         valid_q, we_q, inv_q, den_q;
  logic [2:0]   osa_q;

  assign ops[0] = op_a_i;
  assign ops[1] = op_b_i;

  for (genvar i = 0; i < NOPS; i++) begin : g_cls
    hcmp_classify #(.EW(EW), .MW(MW)) u_cls (
      .op_i  (ops[i]),
      .cls_o (cls[i])
    );
  end

  hcmp_order #(.W(W)) u_ord (
    .op_a_i  (op_a_i),
    .op_b_i  (op_b_i),
    .cls_a_i (cls[0]),
    .cls_b_i (cls[1]),
    .ord_o   (ord)
  );

  hcmp_flag_map u_map (
    .ord_i (ord),
    .flg_o (flg_n)
  );

  assign exc_inv = cls[0].snan | cls[1].snan;
  assign exc_den = cls[0].sub | cls[1].sub;
  // an unmasked exception blocks the architectural flag update
  assign blk     = (exc_inv & ~mask_inv_i) | (exc_den & ~mask_den_i);
  assign wr      = valid_i & ~blk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      we_q    <= 1'b0;
      flg_q   <= '0;
      osa_q   <= '0;
      inv_q   <= 1'b0;
      den_q   <= 1'b0;
    end else begin
      valid_q <= valid_i;
      we_q    <= wr;
      if (wr) begin
        flg_q <= flg_n;
        osa_q <= '0;
      end
      if (valid_i) begin
        inv_q <= inv_q | exc_inv;
        den_q <= den_q | exc_den;
      end
    end
  end

  assign valid_o    = valid_q;
  assign flag_we_o  = we_q;
  assign zf_o       = flg_q.zf;
  assign pf_o       = flg_q.pf;
  assign cf_o       = flg_q.cf;
  assign of_o       = osa_q[2];
  assign sf_o       = osa_q[1];
  assign af_o       = osa_q[0];
  assign stat_inv_o = inv_q;
  assign stat_den_o = den_q;

  AST_CLASS_ONEHOT_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cls[0]) == 1);                                          // R1
  AST_UNORD_PATTERN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_o |-> (zf_o && cf_o));                                          // R1
  AST_OSA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(of_o || sf_o || af_o));                              // R5
  AST_QNAN_NO_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !cls[0].snan && !cls[1].snan) |=> $stable(stat_inv_o)); // R6
  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> $stable({zf_o, pf_o, cf_o}));                              // R8
  AST_STICKY_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_inv_o |=> stat_inv_o);                                        // R9
  AST_STICKY_DEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_den_o |=> stat_den_o);                                        // R9
  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);                                              // R10
  AST_WE_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_o |-> valid_o);                                            // R10
endmodule

// File: tb/hcmp_unit_test.sv
`timescale 1ns/1ps
module hcmp_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic        m_inv = 1'b1, m_den = 1'b1;
  logic        valid_o, zf, pf, cf, of_f, sf, af, we, s_inv, s_den;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic [2:0] flg;
    logic       we;
    logic       inv;
    logic       den;
    string      tag;
  } exp_t;

  exp_t q[$];
  logic [2:0] m_flg = 3'b000;
  logic       m_sinv = 1'b0, m_sden = 1'b0;

  always #4 clk = ~clk;

  hcmp_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .op_a_i(op_a), .op_b_i(op_b), .mask_inv_i(m_inv), .mask_den_i(m_den),
    .valid_o(valid_o), .zf_o(zf), .pf_o(pf), .cf_o(cf),
    .of_o(of_f), .sf_o(sf), .af_o(af), .flag_we_o(we),
    .stat_inv_o(s_inv), .stat_den_o(s_den)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic is_nan(logic [15:0] x);
    return (x[14:10] == 5'h1f) && (x[9:0] != 0);
  endfunction

  // zf,pf,cf per R1..R4 via signed integer key
  function automatic logic [2:0] ref_flags(logic [15:0] a, logic [15:0] b);
    int ka, kb;
    if (is_nan(a) || is_nan(b)) return 3'b111;
    ka = a[15] ? -int'(a[14:0]) : int'(a[14:0]);
    kb = b[15] ? -int'(b[14:0]) : int'(b[14:0]);
    if (ka > kb) return 3'b000;
    if (ka < kb) return 3'b001;
    return 3'b100;
  endfunction

  task automatic send(logic [15:0] a, logic [15:0] b, logic mi, logic md, string tag);
    exp_t e;
    logic inv, den, ok;
    @(negedge clk);
    op_a = a; op_b = b; m_inv = mi; m_den = md; valid_i = 1'b1;
    inv = (is_nan(a) && !a[9]) || (is_nan(b) && !b[9]);
    den = (a[14:10] == 0 && a[9:0] != 0) || (b[14:10] == 0 && b[9:0] != 0);
    ok  = !((inv && !mi) || (den && !md));
    if (ok) m_flg = ref_flags(a, b);
    m_sinv = m_sinv | inv;
    m_sden = m_sden | den;
    e.flg = m_flg; e.we = ok; e.inv = m_sinv; e.den = m_sden; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (q.size() == 0) begin
        check("R10 unexpected valid_o", 8'd1, 8'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " flags"}, {5'd0, zf, pf, cf}, {5'd0, e.flg});
        check("R8 flag_we", {7'd0, we}, {7'd0, e.we});
        check("R5 of/sf/af", {5'd0, of_f, sf, af}, 8'd0);
        check("R6 stat_inv", {7'd0, s_inv}, {7'd0, e.inv});
        check("R7 R9 stat_den", {7'd0, s_den}, {7'd0, e.den});
      end
    end
  end

  initial begin
    #(8ns * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset outputs",
          {valid_o, zf, pf, cf, of_f, sf, af, we},    8'd0);
    check("R11 reset status", {6'd0, s_inv, s_den}, 8'd0);
    rst_n = 1'b1;
    idle(1);

    send(16'h4000, 16'h3C00, 1, 1, "R2 2>1");
    send(16'h3C00, 16'h4000, 1, 1, "R3 1<2");
    send(16'hC000, 16'hBC00, 1, 1, "R3 -2<-1");
    send(16'hBC00, 16'hC000, 1, 1, "R2 -1>-2");
    send(16'h0000, 16'h8000, 1, 1, "R4 +0==-0");
    send(16'h8000, 16'h0000, 1, 1, "R4 -0==+0");
    send(16'h3C00, 16'h3C00, 1, 1, "R4 1==1");
    send(16'hBC00, 16'h3C00, 1, 1, "R3 -1<1");
    send(16'h7C00, 16'h7BFF, 1, 1, "R2 inf>max");
    send(16'hFC00, 16'hC000, 1, 1, "R3 -inf<-2");
    send(16'h7C00, 16'h7C00, 1, 1, "R4 inf==inf");
    idle(2);
    check("R10 valid single pulse", {7'd0, valid_o}, 8'd0);

    send(16'h7E00, 16'h3C00, 0, 0, "R1 R6 qnan unmasked");
    send(16'h3C00, 16'hFE01, 0, 0, "R1 R6 -qnan");
    send(16'h4000, 16'h3C00, 0, 0, "R2 restore");
    idle(1);
    send(16'h7C01, 16'h3C00, 0, 1, "R8 snan unmasked hold");
    idle(1);
    send(16'h3C00, 16'h7D00, 1, 1, "R1 R9 snan masked");
    send(16'h0001, 16'h0000, 1, 0, "R8 den unmasked hold");
    send(16'h0001, 16'h0000, 1, 1, "R7 sub>0 masked");
    send(16'h0001, 16'h0200, 1, 1, "R3 sub<sub");
    send(16'h8001, 16'h0000, 1, 1, "R3 -sub<0");
    send(16'h03FF, 16'h0400, 1, 1, "R3 maxsub<minnorm");
    send(16'h4000, 16'h3C00, 1, 1, "R9 status stays");
    send(16'h7E00, 16'h0001, 1, 1, "R1 qnan with sub");
    idle(3);
    check("R10 queue drained", 8'(q.size()), 8'd0);
    check("R5 of/sf/af idle", {5'd0, of_f, sf, af}, 8'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule